// File: doc/BRIEF.md
# Double-Buffered PWM Timer Channel

The block is a free-running up-counter with a programmable wrap value and two 16-bit compare register sets, driving one PWM output pin. In the plain mode only compare set 0 shapes the pulse. In the linked mode the two sets take turns. Set 0 owns the pulse width first. From then on, each counter wrap hands ownership to whichever set software committed most recently. Software can therefore prepare the next period's width in the idle set without glitching the current period.

Software reaches the block through a byte-wide write port with eight addresses. Each 16-bit register is written as a high byte, which is staged, and then a low byte, which commits both halves. The timer control byte stops the counter or clears it. The channel control byte picks the mode and the pulse polarity. In each period the output sits at the active level while the count is below the owning compare value and at the inactive level afterwards. A compare of zero gives a clean 0% duty cycle. A compare above the wrap value gives 100%.

The ownership logic is a four-state machine. OWN_OFF means the channel is disabled and the output is held low. OWN_SINGLE is the plain mode, with set 0 in use. OWN_LINK0 is linked with set 0 owning, and OWN_LINK1 is linked with set 1 owning. A channel control write moves the machine from any state to OWN_OFF, OWN_SINGLE or OWN_LINK0. Entering OWN_LINK0 from an unlinked state clears the last-written flag to set 0. A write that keeps linked mode leaves the state unchanged. At a counter wrap the machine moves between OWN_LINK0 and OWN_LINK1 according to the last-written flag.

Top module: `dbpwm_timer`

## Requirements
- R1: After reset the output is 0, the channel is disabled, the counter is 0 and the wrap value is 0xFFFF.
- R2: While running, the counter steps by one each cycle. At the cycle after it has reached or passed the wrap value it reads 0, so a period lasts wrap+1 cycles.
- R3: Address 6 is the timer control byte. Bit 0 is the stop bit, and while it is 1 the counter and output hold. Writing 1 to bit 1 clears the counter to 0 on that edge, and bit 1 is not stored.
- R4: Address 7 is the channel control byte, with mode in bits [3:2] and polarity in bits [1:0]. Mode 01 selects plain PWM, where only set 0 (addresses 2 and 3) sets the width. Writes to set 1 (addresses 4 and 5) have no effect on the output in this mode.
- R5: With polarity 10 the output is 1 while count < compare and 0 otherwise. With polarity 11 the output is 0 while count < compare and 1 otherwise. With polarity 00 or 01 the output is 0.
- R6: A compare value of 0 holds the inactive level for the whole period. A compare value above the wrap value holds the active level for the whole period.
- R7: A high-byte write (addresses 0, 2 and 4) only stages the byte. A 16-bit register (wrap at 0/1, set 0 at 2/3, set 1 at 4/5) changes only when its low byte is written, and it then takes the staged high byte.
- R8: Writing mode 10 from a non-linked state enters linked mode with set 0 owning the width.
- R9: In linked mode, a write to the set that does not own the width leaves the current period unchanged. That width first applies at count 0 of the next period.
- R10: At every counter wrap in linked mode, ownership goes to the set whose low byte was written most recently, so alternating writes swap ownership at each wrap.
- R11: A write to the set that currently owns the width changes the output from the next cycle, with no buffering.
- R12: Mode 00 or 11 disables the channel and the output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe, one byte per cycle |
| wr_addr | input | 3 | Register address: 0/1 wrap hi/lo, 2/3 set 0 hi/lo, 4/5 set 1 hi/lo, 6 timer control, 7 channel control |
| wr_data | input | 8 | Write data byte |
| pwm_out | output | 1 | PWM output pin |

## Verification
The bench writes to the idle set in the middle of a period. A design that swapped sets on the write instead of at the wrap would show the new width one period early. It also alternates writes between the two sets around wraps, which exposes a design that remembers the first write instead of the last, or that swaps only once. It drives compares of 0 and above the wrap value, where a toggle-based output would lose the 0% or 100% level. It writes lone high bytes, where a design without staging would pick up a half-updated width. Stop and clear writes are mixed in at random.

// File: rtl/dbpwm_pkg.sv
package dbpwm_pkg;
    typedef enum logic [1:0] {
        OWN_OFF    = 2'd0,
        OWN_SINGLE = 2'd1,
        OWN_LINK0  = 2'd2,
        OWN_LINK1  = 2'd3
    } own_state_e;

    localparam logic [2:0] A_TCTL = 3'd6;
    localparam logic [2:0] A_CCTL = 3'd7;
    localparam int unsigned NUM_WREG = 3;   // wrap, set 0, set 1

    localparam logic [1:0] MS_UNBUF = 2'b01;
    localparam logic [1:0] MS_BUF   = 2'b10;
endpackage

// File: rtl/dbpwm_regs.sv
module dbpwm_regs
    import dbpwm_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [2:0]            wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    output logic [2*DATA_W-1:0]   mod_val,
    output logic [2*DATA_W-1:0]   c0_val,
    output logic [2*DATA_W-1:0]   c1_val,
    output logic                  c0_commit,
    output logic                  c1_commit,
    output logic                  stop_q,
    output logic                  clr_pulse,
    output logic                  cctl_wr,
    output logic [1:0]            ms_new,
    output logic [1:0]            els_q
);
    localparam int VAL_W = 2 * DATA_W;

    logic [VAL_W-1:0] val_q [NUM_WREG];
    logic             commit [NUM_WREG];

    for (genvar g = 0; g < NUM_WREG; g++) begin : g_wreg
        localparam logic [2:0] HI_A = 3'(2 * g);
        localparam logic [2:0] LO_A = 3'(2 * g + 1);
        localparam logic [VAL_W-1:0] RST_V = (g == 0) ? {VAL_W{1'b1}} : '0;
        logic [DATA_W-1:0] stage_q;

        assign commit[g] = wr_en && (wr_addr == LO_A);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q  <= '0;
                val_q[g] <= RST_V;
            end else begin
                if (wr_en && (wr_addr == HI_A))
                    stage_q <= wr_data;
                if (commit[g])
                    val_q[g] <= {stage_q, wr_data};
            end
        end
    end

    assign mod_val   = val_q[0];
    assign c0_val    = val_q[1];
    assign c1_val    = val_q[2];
    assign c0_commit = commit[1];
    assign c1_commit = commit[2];

    assign clr_pulse = wr_en && (wr_addr == A_TCTL) && wr_data[1];
    assign cctl_wr   = wr_en && (wr_addr == A_CCTL);
    assign ms_new    = wr_data[3:2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stop_q <= 1'b0;
            els_q  <= 2'b00;
        end else begin
            if (wr_en && (wr_addr == A_TCTL))
                stop_q <= wr_data[0];
            if (cctl_wr)
                els_q <= wr_data[1:0];
        end
    end
endmodule

// File: rtl/dbpwm_counter.sv
module dbpwm_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stop,
    input  logic             clr,
    input  logic [CNT_W-1:0] mod_val,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf
);
    logic at_wrap;

    assign at_wrap = (cnt >= mod_val);
    assign ovf     = !stop && !clr && at_wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (!stop)
            cnt <= at_wrap ? '0 : cnt + 1'b1;
    end
endmodule

// File: rtl/dbpwm_owner_fsm.sv
module dbpwm_owner_fsm
    import dbpwm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cctl_wr,
    input  logic [1:0] ms_new,
    input  logic       c0_commit,
    input  logic       c1_commit,
    input  logic       ovf,
    output own_state_e state,
    output logic       sel_ch1,
    output logic       chan_en
);
    own_state_e st_d;
    logic       last_q;
    logic       last_eff;
    logic       last_d;
    logic       linked;

    assign linked   = (state == OWN_LINK0) || (state == OWN_LINK1);
    assign last_eff = c1_commit ? 1'b1 : (c0_commit ? 1'b0 : last_q);

    always_comb begin
        st_d   = state;
        last_d = last_eff;
        if (cctl_wr) begin
            unique case (ms_new)
                MS_UNBUF: st_d = OWN_SINGLE;
                MS_BUF: begin
                    if (!linked) begin
                        st_d   = OWN_LINK0;
                        last_d = 1'b0;
                    end
                end
                default:  st_d = OWN_OFF;
            endcase
        end else if (ovf) begin
            unique case (state)
                OWN_LINK0, OWN_LINK1: st_d = last_eff ? OWN_LINK1 : OWN_LINK0;
                default:              st_d = state;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= OWN_OFF;
            last_q <= 1'b0;
        end else begin
            state  <= st_d;
            last_q <= last_d;
        end
    end

    always_comb begin
        sel_ch1 = 1'b0;
        chan_en = 1'b1;
        unique case (state)
            OWN_OFF:    chan_en = 1'b0;
            OWN_SINGLE: sel_ch1 = 1'b0;
            OWN_LINK0:  sel_ch1 = 1'b0;
            OWN_LINK1:  sel_ch1 = 1'b1;
        endcase
    end
endmodule

// File: rtl/dbpwm_timer.sv
module dbpwm_timer
    import dbpwm_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              pwm_out
);
    localparam int CNT_W = 2 * DATA_W;

    logic [CNT_W-1:0] mod_val, c0_val, c1_val, cnt, cmp_act;
    logic             c0_commit, c1_commit, stop_q, clr_pulse, cctl_wr;
    logic             ovf, sel_ch1, chan_en, in_pulse;
    logic [1:0]       ms_new, els_q;
    own_state_e       state;

    dbpwm_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .mod_val(mod_val), .c0_val(c0_val), .c1_val(c1_val),
        .c0_commit(c0_commit), .c1_commit(c1_commit), .stop_q(stop_q),
        .clr_pulse(clr_pulse), .cctl_wr(cctl_wr), .ms_new(ms_new), .els_q(els_q)
    );

    dbpwm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .stop(stop_q), .clr(clr_pulse),
        .mod_val(mod_val), .cnt(cnt), .ovf(ovf)
    );

    dbpwm_owner_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .cctl_wr(cctl_wr), .ms_new(ms_new),
        .c0_commit(c0_commit), .c1_commit(c1_commit), .ovf(ovf),
        .state(state), .sel_ch1(sel_ch1), .chan_en(chan_en)
    );

    assign cmp_act  = sel_ch1 ? c1_val : c0_val;
    assign in_pulse = (cnt < cmp_act);
    assign pwm_out  = chan_en && els_q[1] && (in_pulse ^ els_q[0]);
endmodule

// File: rtl/dbpwm_checker.sv
module dbpwm_checker
    import dbpwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] mod_val,
    input logic [CNT_W-1:0] c0_val,
    input logic             c0_commit,
    input logic             stop_q,
    input logic             clr_pulse,
    input logic [1:0]       els_q,
    input own_state_e       state,
    input logic             pwm_out
);
    logic run_wrap;
    assign run_wrap = !stop_q && !clr_pulse && (cnt >= mod_val);

    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        run_wrap |=> (cnt == '0)); // R2
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop_q && !clr_pulse && (cnt < mod_val)) |=> (cnt == $past(cnt) + 1'b1)); // R2
    AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_q && !clr_pulse) |=> $stable(cnt)); // R3
    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr_pulse |=> (cnt == '0)); // R3
    AST_HALF_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !c0_commit |=> $stable(c0_val)); // R7
    AST_SWAP_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == OWN_LINK1) && ($past(state) == OWN_LINK0)) |-> $past(run_wrap)); // R10
    AST_ZERO_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == OWN_SINGLE) && (els_q == 2'b10) && (c0_val == '0)) |-> !pwm_out); // R6
    AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state == OWN_OFF) |-> !pwm_out); // R12
endmodule

bind dbpwm_timer dbpwm_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .mod_val(mod_val), .c0_val(c0_val),
    .c0_commit(c0_commit), .stop_q(stop_q), .clr_pulse(clr_pulse),
    .els_q(els_q), .state(state), .pwm_out(pwm_out)
);

// File: tb/dbpwm_timer_bench.sv
module dbpwm_timer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       pwm_out;

    int    checks = 0;
    int    fails = 0;
    int    cyc = 0;
    bit    done = 1'b0;
    string cur_tag = "R1";

    // bench reference model, updated from the requirements
    logic [15:0] m_mod, m_cnt;
    logic [15:0] m_val [3];
    logic [7:0]  m_stage [3];
    logic        m_stop, m_last;
    logic [1:0]  m_els;
    int          m_st;   // 0 off, 1 plain, 2 linked set0, 3 linked set1

    dbpwm_timer u_dbpwm_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pwm_out(pwm_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic exp_pwm();
        logic [15:0] cmp;
        cmp = (m_st == 3) ? m_val[2] : m_val[1];
        return (m_st != 0) && m_els[1] && ((m_cnt < cmp) ^ m_els[0]);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mod = 16'hFFFF; m_cnt = '0; m_stop = 0; m_last = 0; m_els = 0; m_st = 0;
            for (int i = 0; i < 3; i++) begin
                m_val[i] = (i == 0) ? 16'hFFFF : 16'h0;
                m_stage[i] = '0;
            end
        end else begin
            logic clr, ovf, c0c, c1c, le, ln;
            int st_n;
            logic [15:0] cnt_n;
            clr = wr_en && wr_addr == 3'd6 && wr_data[1];
            ovf = !m_stop && !clr && (m_cnt >= m_mod);
            cnt_n = clr ? 16'd0 : (m_stop ? m_cnt : ((m_cnt >= m_mod) ? 16'd0 : m_cnt + 16'd1));
            c0c = wr_en && wr_addr == 3'd3;
            c1c = wr_en && wr_addr == 3'd5;
            le = c1c ? 1'b1 : (c0c ? 1'b0 : m_last);
            ln = le;
            st_n = m_st;
            if (wr_en && wr_addr == 3'd7) begin
                if (wr_data[3:2] == 2'b01) st_n = 1;
                else if (wr_data[3:2] == 2'b10) begin
                    if (m_st < 2) begin st_n = 2; ln = 0; end
                end else st_n = 0;
            end else if (ovf && m_st >= 2) st_n = le ? 3 : 2;
            if (wr_en) begin
                if (wr_addr <= 3'd5) begin
                    if (wr_addr[0] == 1'b0) m_stage[wr_addr/2] = wr_data;
                    else m_val[wr_addr/2] = {m_stage[wr_addr/2], wr_data};
                end
                if (wr_addr == 3'd6) m_stop = wr_data[0];
                if (wr_addr == 3'd7) m_els = wr_data[1:0];
            end
            m_mod = m_val[0];
            m_cnt = cnt_n; m_st = st_n; m_last = ln;
        end
    end

    task automatic check_bit(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: pwm_out actual=%0b expected=%0b at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    task automatic check_int(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // one cycle: compare the output with the model, then drive the inputs
    task automatic step(logic we, logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        check_bit(cur_tag, pwm_out, exp_pwm());
        wr_en = we; wr_addr = a; wr_data = d;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 3'd0, 8'd0);
    endtask

    task automatic wr16(logic [2:0] hi_a, logic [15:0] v);
        step(1, hi_a, v[15:8]);
        step(1, hi_a + 3'd1, v[7:0]);
    endtask

    task automatic ones_in(int n, output int k);
        k = 0;
        for (int i = 0; i < n; i++) begin
            step(0, 3'd0, 8'd0);
            k += int'(pwm_out);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG && !done) begin
            done = 1'b1;
            fails++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        int k;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        checks++;
        if (pwm_out !== 1'b0) begin fails++; $display("FAIL R1: pwm_out actual=%0b expected=0", pwm_out); end
        @(negedge clk); rst_n = 1'b1;
        cur_tag = "R1"; idle(5);

        cur_tag = "R12"; step(1, 3'd7, 8'h0E); idle(4);      // mode 11 -> off
        step(1, 3'd7, 8'h02); idle(4);                        // mode 00 -> off

        cur_tag = "R2"; wr16(3'd0, 16'd9); wr16(3'd2, 16'd4);
        step(1, 3'd6, 8'h02);                                 // clear to start clean
        step(1, 3'd7, 8'h06); idle(12);                       // plain, active high
        ones_in(10, k); check_int("R2 ones per 10-cycle period", k, 4);

        cur_tag = "R5"; step(1, 3'd7, 8'h07); idle(10);
        ones_in(10, k); check_int("R5 active-low ones", k, 6);
        step(1, 3'd7, 8'h05); idle(10);
        ones_in(10, k); check_int("R5 polarity 01 gives 0", k, 0);
        step(1, 3'd7, 8'h06);

        cur_tag = "R4"; wr16(3'd4, 16'd8); idle(10);
        ones_in(10, k); check_int("R4 set 1 ignored in plain mode", k, 4);

        cur_tag = "R6"; wr16(3'd2, 16'd0); idle(10);
        ones_in(10, k); check_int("R6 zero compare", k, 0);
        wr16(3'd2, 16'h0020); idle(10);
        ones_in(10, k); check_int("R6 compare above wrap", k, 10);

        cur_tag = "R7"; step(1, 3'd2, 8'h00); idle(10);
        ones_in(10, k); check_int("R7 high byte alone", k, 10);
        step(1, 3'd3, 8'h03); idle(10);
        ones_in(10, k); check_int("R7 low byte commits", k, 3);

        cur_tag = "R3"; step(1, 3'd6, 8'h01); idle(3);
        k = int'(pwm_out);
        idle(12);
        check_int("R3 stopped output holds", int'(pwm_out), k);
        step(1, 3'd6, 8'h03); idle(1);
        check_int("R3 clear gives count 0 active", int'(pwm_out), 1);
        step(1, 3'd6, 8'h00); idle(12);

        cur_tag = "R8"; step(1, 3'd7, 8'h0A); idle(12);
        ones_in(10, k); check_int("R8 set 0 owns first", k, 3);

        cur_tag = "R9"; idle(5); wr16(3'd4, 16'd7); idle(12);
        ones_in(10, k); check_int("R9 set 1 after wrap", k, 7);

        cur_tag = "R10"; wr16(3'd2, 16'd2); idle(12);
        ones_in(10, k); check_int("R10 last written owns", k, 2);
        for (int p = 0; p < 6; p++) begin
            wr16(3'd4, 16'(5 + p)); idle(3);
            wr16(3'd2, 16'(1 + p)); idle(1);
        end

        cur_tag = "R11"; idle(10); wr16(3'd2, 16'd6); idle(3);
        wr16(3'd2, 16'd1); idle(12);
        ones_in(10, k); check_int("R11 active set write", k, 1);

        cur_tag = "RANDOM R9 R10 R11";
        for (int n = 0; n < 3000; n++) begin
            int r;
            r = int'($urandom % 16);
            if (r < 6) wr16(3'd2, 16'($urandom % 14));
            else if (r < 11) wr16(3'd4, 16'($urandom % 14));
            else if (r == 11) wr16(3'd0, 16'(4 + $urandom % 9));
            else if (r == 12) begin
                logic [1:0] ms;
                ms = ($urandom % 4 == 0) ? 2'($urandom) : 2'b10;
                step(1, 3'd7, {4'b0, ms, 1'b1, 1'($urandom)});
            end else if (r == 13) step(1, 3'd6, {6'b0, 1'($urandom % 4 == 0), 1'($urandom % 4 == 0)});
            else if (r == 14) step(1, 3'(2 * ($urandom % 3)), 8'($urandom));
            else idle(1 + int'($urandom % 6));
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule